// File: doc/BRIEF.md
# Autonomous Link Speed Escalation Sequencer

This block sits on the root-port side of a serial link controller. It runs after the link has completed its first training at the base rate (Gen1). It then raises the link rate toward the fastest rate that both ends support. The inputs it uses are the rates each side advertises, a per-rate disable mask and two equalization capability flags. Each step is a single request to a lower-level training engine. The request names a target rate and says whether equalization is needed. The block then waits for a done or fail answer before it decides the next step.

The climb does not go one generation at a time. From Gen1 the sequencer goes straight to Gen3 when Gen3 is common to both sides. Gen4 and Gen5 are each tried only after the rate below them was reached. A failed attempt leaves the link resting at the last rate that worked. Software may then ask for the attempt to be repeated. In endpoint mode the sequencer does nothing. A mask that breaks the allowed combinations raises an error flag and suppresses every attempt.

Top module: `spd_escalator`

## Requirements
- R1: After reset the block reports speed 1 (encoding: `curSpeed` holds the generation number, 1 to 5), with `busy`, `chgReq` and `maskErr` low.
- R2: With `rootMode` low, a `trainDone` pulse starts nothing: `busy` and `chgReq` stay low and `curSpeed` stays 1.
- R3: From Gen1 a request for target 2 with `chgEq` low is issued when both capability vectors have bit 0 set (bit i means Gen(i+2)) and mask bit 0 is clear, provided Gen3 is not both common and enabled.
- R4: From Gen1 a direct request for target 3 with `chgEq` high is issued when both sides have capability bit 1 set and mask bit 1 is clear.
- R5: A request for target 4 is issued only from speed 3, only when both sides have bit 2 set and mask bits 2 and 1 are both clear.
- R6: A request for target 5 is issued only from speed 4, when both sides have bit 3 set and mask bit 3 is clear.
- R7: When a request is answered with `chgFail`, the block rests at the speed it held before the attempt. That is 1 after a Gen2 or Gen3 attempt, 3 after Gen4 and 4 after Gen5, and `busy` drops on the next cycle.
- R8: Only one request is outstanding at a time. `chgReq` and `chgTarget` hold steady until `chgDone` or `chgFail` arrives, and `chgReq` is low for at least one cycle after each answer.
- R9: The mask (bit 3 = Gen5 ... bit 0 = Gen2) must be 0000, 1000, 1100, 1110 or 1111 when neither equalization flag is set, and 0000, 1110 or 1111 when either is set. Any other value sets `maskErr`, no request is issued and the speed stays 1.
- R10: A `swRetrain` pulse while resting after a failed attempt repeats escalation from the current speed. Without a pending failure, the pulse is ignored.
- R11: `busy` rises on the cycle after an accepted `trainDone` or `swRetrain` and falls once the link rests at its final speed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rootMode | input | 1 | High when the controller acts as root port (static strap) |
| trainDone | input | 1 | One-cycle pulse: initial training reached L0 at Gen1 |
| localCap | input | 4 | Local rate support, bit i = Gen(i+2) |
| peerCap | input | 4 | Link partner rate support, bit i = Gen(i+2) |
| disMask | input | 4 | Per-rate escalation disable, bit i = Gen(i+2) |
| noEqAdv | input | 1 | No-equalization capability advertised |
| eqBypassAdv | input | 1 | Equalization bypass to highest rate advertised |
| swRetrain | input | 1 | One-cycle pulse: software asks to repeat a failed escalation |
| chgReq | output | 1 | Speed-change request to the training engine |
| chgTarget | output | 3 | Target generation of the request |
| chgEq | output | 1 | Request needs equalization |
| chgDone | input | 1 | Training engine reports success |
| chgFail | input | 1 | Training engine reports failure |
| curSpeed | output | 3 | Generation the link currently rests at |
| busy | output | 1 | Escalation in progress |
| maskErr | output | 1 | Disable mask was illegal at the last start |

## Verification
On every cycle, the assertions check the per-step rules. Each request target must come from the correct starting speed with the correct equalization flag. A waiting request must stay stable, a failure must hold the speed, a flagged mask must block requests, and endpoint mode must stay quiet. Only the bench scenarios can show the full climbs as a whole: the order of attempted targets for each capability and mask mix, the exact resting speed after a failure at each rate, and the legal/illegal split of masks under each equalization flag. The same holds for whether a software retry is honoured or ignored depending on a prior failure.

// File: rtl/spd_pkg.sv
package spd_pkg;
  localparam int GEN_W = 3;
  localparam int CAP_W = 4;

  typedef logic [GEN_W-1:0] gen_t;

  localparam gen_t GEN1 = 3'd1;
  localparam gen_t GEN2 = 3'd2;
  localparam gen_t GEN3 = 3'd3;
  localparam gen_t GEN4 = 3'd4;
  localparam gen_t GEN5 = 3'd5;

  typedef enum logic [1:0] {ST_IDLE, ST_EVAL, ST_REQ, ST_REST} seq_state_t;

  typedef struct packed {
    logic startFresh;
    logic startRetry;
    logic loadTgt;
    logic commit;
    logic markFail;
  } dp_strobe_t;

  // Legal masks keep the disabled rates contiguous from the top.
  function automatic logic maskLegal(logic [CAP_W-1:0] m, logic relaxed);
    logic [CAP_W-1:0] inv;
    logic             thermo;
    inv    = ~m;
    thermo = ((inv & (inv + 1'b1)) == '0);
    return thermo && (!relaxed || (m == '0) || m[1]);
  endfunction
endpackage

// File: rtl/spd_datapath.sv
module spd_datapath
  import spd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dp_strobe_t       strobe,
  input  logic [CAP_W-1:0] localCap,
  input  logic [CAP_W-1:0] peerCap,
  input  logic [CAP_W-1:0] disMask,
  input  logic             noEqAdv,
  input  logic             eqBypassAdv,
  output gen_t             curSpeed,
  output gen_t             tgtSpeed,
  output logic             maskErr,
  output logic             lastFail,
  output logic             stepAvail
);
  logic [CAP_W-1:0] snapMask;
  logic [CAP_W-1:0] commonCap;
  logic             hasNext;
  gen_t             nextTgt;
  logic             anyStart;

  assign anyStart = strobe.startFresh | strobe.startRetry;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      snapMask  <= '0;
      commonCap <= '0;
      maskErr   <= 1'b0;
    end else if (anyStart) begin
      snapMask  <= disMask;
      commonCap <= localCap & peerCap;
      maskErr   <= !maskLegal(disMask, noEqAdv | eqBypassAdv);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curSpeed <= GEN1;
      tgtSpeed <= GEN1;
      lastFail <= 1'b0;
    end else begin
      if (strobe.startFresh) curSpeed <= GEN1;
      else if (strobe.commit) curSpeed <= tgtSpeed;
      if (strobe.loadTgt) tgtSpeed <= nextTgt;
      if (anyStart) lastFail <= 1'b0;
      else if (strobe.markFail) lastFail <= 1'b1;
    end
  end

  // Next rate from the current resting rate, using the snapshot.
  always_comb begin
    hasNext = 1'b0;
    nextTgt = curSpeed;
    case (curSpeed)
      GEN1: begin
        if (commonCap[1] && !snapMask[1]) begin
          hasNext = 1'b1;
          nextTgt = GEN3;
        end else if (commonCap[0] && !snapMask[0]) begin
          hasNext = 1'b1;
          nextTgt = GEN2;
        end
      end
      GEN3: begin
        if (commonCap[2] && !snapMask[2] && !snapMask[1]) begin
          hasNext = 1'b1;
          nextTgt = GEN4;
        end
      end
      GEN4: begin
        if (commonCap[3] && !snapMask[3]) begin
          hasNext = 1'b1;
          nextTgt = GEN5;
        end
      end
      default: ;
    endcase
  end

  assign stepAvail = hasNext & !maskErr;

  // R5: Gen4 committed only on top of Gen3
  a_r5_gen4_base: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && tgtSpeed == GEN4) |-> curSpeed == GEN3);
  // R6: Gen5 committed only on top of Gen4
  a_r6_gen5_base: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && tgtSpeed == GEN5) |-> curSpeed == GEN4);
  // R9: a flagged mask never loads a target
  a_r9_err_blocks: assert property (@(posedge clk) disable iff (!rstN)
    maskErr |-> !strobe.loadTgt);
endmodule

// File: rtl/spd_control.sv
module spd_control
  import spd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rootMode,
  input  logic       trainDone,
  input  logic       swRetrain,
  input  logic       chgDone,
  input  logic       chgFail,
  input  logic       stepAvail,
  input  logic       lastFail,
  output dp_strobe_t strobe,
  output logic       busy,
  output logic       chgReq
);
  seq_state_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE, ST_REST: begin
        if (rootMode && trainDone) begin
          strobe.startFresh = 1'b1;
          stateNext = ST_EVAL;
        end else if (state == ST_REST && rootMode && swRetrain && lastFail) begin
          strobe.startRetry = 1'b1;
          stateNext = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (stepAvail) begin
          strobe.loadTgt = 1'b1;
          stateNext = ST_REQ;
        end else begin
          stateNext = ST_REST;
        end
      end
      ST_REQ: begin
        if (chgDone) begin
          strobe.commit = 1'b1;
          stateNext = ST_EVAL;
        end else if (chgFail) begin
          strobe.markFail = 1'b1;
          stateNext = ST_REST;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else state <= stateNext;
  end

  assign busy   = (state == ST_EVAL) || (state == ST_REQ);
  assign chgReq = (state == ST_REQ);

  // R8: a waiting request stays up until answered
  a_r8_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (chgReq && !chgDone && !chgFail) |=> chgReq);
  // R8: a gap follows every answer
  a_r8_gap: assert property (@(posedge clk) disable iff (!rstN)
    (chgReq && (chgDone || chgFail)) |=> !chgReq);
  // R11: work only starts from a start pulse
  a_r11_busy_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(trainDone || swRetrain));
  // R10: a retry without a pending failure is ignored
  a_r10_retry_gate: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REST && swRetrain && !lastFail && !trainDone) |=> !busy);
  // R2: endpoint mode stays quiet
  a_r2_ep_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!rootMode && !busy) |=> !busy);
endmodule

// File: rtl/spd_escalator.sv
module spd_escalator
  import spd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             rootMode,
  input  logic             trainDone,
  input  logic [CAP_W-1:0] localCap,
  input  logic [CAP_W-1:0] peerCap,
  input  logic [CAP_W-1:0] disMask,
  input  logic             noEqAdv,
  input  logic             eqBypassAdv,
  input  logic             swRetrain,
  output logic             chgReq,
  output logic [GEN_W-1:0] chgTarget,
  output logic             chgEq,
  input  logic             chgDone,
  input  logic             chgFail,
  output logic [GEN_W-1:0] curSpeed,
  output logic             busy,
  output logic             maskErr
);
  dp_strobe_t strobe;
  gen_t       tgtSpeed;
  logic       lastFail;
  logic       stepAvail;

  spd_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rootMode  (rootMode),
    .trainDone (trainDone),
    .swRetrain (swRetrain),
    .chgDone   (chgDone),
    .chgFail   (chgFail),
    .stepAvail (stepAvail),
    .lastFail  (lastFail),
    .strobe    (strobe),
    .busy      (busy),
    .chgReq    (chgReq)
  );

  spd_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .localCap    (localCap),
    .peerCap     (peerCap),
    .disMask     (disMask),
    .noEqAdv     (noEqAdv),
    .eqBypassAdv (eqBypassAdv),
    .curSpeed    (curSpeed),
    .tgtSpeed    (tgtSpeed),
    .maskErr     (maskErr),
    .lastFail    (lastFail),
    .stepAvail   (stepAvail)
  );

  assign chgTarget = tgtSpeed;
  assign chgEq     = (tgtSpeed >= GEN3);

  // R3: Gen2 requests leave Gen1 without equalization
  a_r3_gen2_req: assert property (@(posedge clk) disable iff (!rstN)
    (chgReq && chgTarget == GEN2) |-> (curSpeed == GEN1 && !chgEq));
  // R4: Gen3 requests leave Gen1 with equalization
  a_r4_gen3_req: assert property (@(posedge clk) disable iff (!rstN)
    (chgReq && chgTarget == GEN3) |-> (curSpeed == GEN1 && chgEq));
  // R8: the target holds while waiting
  a_r8_tgt_stable: assert property (@(posedge clk) disable iff (!rstN)
    (chgReq && !chgDone && !chgFail) |=> $stable(chgTarget));
  // R7: a failure keeps the last good speed and ends the run
  a_r7_fail_hold: assert property (@(posedge clk) disable iff (!rstN)
    (chgReq && chgFail && !chgDone) |=> (!busy && $stable(curSpeed)));
  // R9: no request while the mask is flagged
  a_r9_err_no_req: assert property (@(posedge clk) disable iff (!rstN)
    maskErr |-> !chgReq);
endmodule

// File: tb/spd_escalator_tb.sv
module spd_escalator_tb;
  localparam int LAT = 3;
  localparam int WATCHDOG = 100000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rootMode = 1'b0, trainDone = 1'b0, swRetrain = 1'b0;
  logic [3:0] localCap = '0, peerCap = '0, disMask = '0;
  logic       noEqAdv = 1'b0, eqBypassAdv = 1'b0;
  logic       chgDone = 1'b0, chgFail = 1'b0;
  logic       chgReq, chgEq, busy, maskErr;
  logic [2:0] chgTarget, curSpeed;

  int checks = 0, errors = 0, cycles = 0;
  int attemptLog = 0, eqLog = 0, attemptIdx = 0, outcomeBits = 0;
  int latCnt = 0, holdTgt = 0, stabErr = 0;
  bit finished = 0;

  // Reference model state
  int mState = 0, mCur = 1, mTgt = 1, mErr = 0, mFail = 0, mMask = 0, mCom = 0;

  always #10 clk = ~clk;

  spd_escalator u_dut (
    .clk(clk), .rstN(rstN), .rootMode(rootMode), .trainDone(trainDone),
    .localCap(localCap), .peerCap(peerCap), .disMask(disMask),
    .noEqAdv(noEqAdv), .eqBypassAdv(eqBypassAdv), .swRetrain(swRetrain),
    .chgReq(chgReq), .chgTarget(chgTarget), .chgEq(chgEq),
    .chgDone(chgDone), .chgFail(chgFail), .curSpeed(curSpeed),
    .busy(busy), .maskErr(maskErr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int modelLegal(input int m, input int relaxed);
    if (relaxed != 0) return (m == 0 || m == 14 || m == 15) ? 1 : 0;
    return (m == 0 || m == 8 || m == 12 || m == 14 || m == 15) ? 1 : 0;
  endfunction

  function automatic int modelNext();
    if (mCur == 1) begin
      if (mCom[1] && !mMask[1]) return 3;
      if (mCom[0] && !mMask[0]) return 2;
    end else if (mCur == 3) begin
      if (mCom[2] && !mMask[2] && !mMask[1]) return 4;
    end else if (mCur == 4) begin
      if (mCom[3] && !mMask[3]) return 5;
    end
    return 0;
  endfunction

  task automatic modelSnap();
    mMask = int'(disMask);
    mCom  = int'(localCap & peerCap);
    mErr  = modelLegal(mMask, int'(noEqAdv | eqBypassAdv)) == 0 ? 1 : 0;
    mFail = 0;
  endtask

  always @(posedge clk) begin
    int nx;
    if (!rstN) begin
      mState = 0; mCur = 1; mTgt = 1; mErr = 0; mFail = 0; mMask = 0; mCom = 0;
    end else begin
      case (mState)
        0, 3: begin
          if (rootMode && trainDone) begin
            mCur = 1; modelSnap(); mState = 1;
          end else if (mState == 3 && rootMode && swRetrain && mFail != 0) begin
            modelSnap(); mState = 1;
          end
        end
        1: begin
          nx = modelNext();
          if (mErr == 0 && nx != 0) begin mTgt = nx; mState = 2; end
          else mState = 3;
        end
        2: begin
          if (chgDone) begin mCur = mTgt; mState = 1; end
          else if (chgFail) begin mFail = 1; mState = 3; end
        end
        default: mState = 0;
      endcase
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(busy == (mState == 1 || mState == 2), "R11 model busy", int'(busy), int'(mState == 1 || mState == 2));
      check(chgReq == (mState == 2), "R8 model chgReq", int'(chgReq), int'(mState == 2));
      check(int'(curSpeed) == mCur, "R7 model curSpeed", int'(curSpeed), mCur);
      check(maskErr == (mErr != 0), "R9 model maskErr", int'(maskErr), mErr);
      if (mState == 2) begin
        check(int'(chgTarget) == mTgt, "R5 model chgTarget", int'(chgTarget), mTgt);
        check(chgEq == (mTgt >= 3), "R4 model chgEq", int'(chgEq), int'(mTgt >= 3));
      end
    end
  end

  // Training-engine responder
  always @(negedge clk) begin
    if (chgDone || chgFail) begin
      chgDone = 1'b0; chgFail = 1'b0;
    end else if (chgReq) begin
      if (latCnt == 0) holdTgt = int'(chgTarget);
      else if (int'(chgTarget) != holdTgt) stabErr++;
      if (latCnt == LAT) begin
        attemptLog = attemptLog * 10 + int'(chgTarget);
        eqLog = eqLog * 2 + int'(chgEq);
        if (outcomeBits[attemptIdx]) chgDone = 1'b1; else chgFail = 1'b1;
        attemptIdx++;
        latCnt = 0;
      end else begin
        latCnt++;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG && !finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic settle();
    int n = 0;
    repeat (2) @(negedge clk);
    while ((busy || chgReq) && n < 300) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic setup(input bit root, input int lc, input int pc, input int mask,
                       input bit noeq, input bit byp, input int outs);
    @(negedge clk);
    rootMode = root; localCap = 4'(lc); peerCap = 4'(pc); disMask = 4'(mask);
    noEqAdv = noeq; eqBypassAdv = byp;
    outcomeBits = outs; attemptIdx = 0; attemptLog = 0; eqLog = 0;
  endtask

  task automatic startLink(input string tag, input bit expBusy);
    trainDone = 1'b1;
    @(negedge clk);
    trainDone = 1'b0;
    check(busy == expBusy, tag, int'(busy), int'(expBusy));
    settle();
  endtask

  task automatic retry(input int outs, input string tag, input bit expBusy);
    @(negedge clk);
    outcomeBits = outs; attemptIdx = 0; attemptLog = 0; eqLog = 0;
    swRetrain = 1'b1;
    @(negedge clk);
    swRetrain = 1'b0;
    check(busy == expBusy, tag, int'(busy), int'(expBusy));
    settle();
  endtask

  task automatic expectEnd(input string tag, input int expLog, input int expSpd, input int expErr);
    check(attemptLog == expLog, {tag, " attempts"}, attemptLog, expLog);
    check(int'(curSpeed) == expSpd, {tag, " speed"}, int'(curSpeed), expSpd);
    check(int'(maskErr) == expErr, {tag, " maskErr"}, int'(maskErr), expErr);
    check(!busy, {tag, " idle"}, int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(curSpeed == 3'd1 && !busy && !chgReq && !maskErr, "R1 reset state", int'(curSpeed), 1);
    rstN = 1'b1;
    @(negedge clk);
    check(curSpeed == 3'd1 && !busy && !chgReq && !maskErr, "R1 after reset", int'(curSpeed), 1);

    // R2: endpoint mode ignores training completion
    setup(1'b0, 15, 15, 0, 1'b0, 1'b0, 'hF);
    startLink("R2 busy after start", 1'b0);
    expectEnd("R2 endpoint", 0, 1, 0);

    // R4 R5 R6: full climb 3 -> 4 -> 5
    setup(1'b1, 15, 15, 0, 1'b0, 1'b0, 'hF);
    startLink("R11 busy after start", 1'b1);
    expectEnd("R6 full climb", 345, 5, 0);
    check(eqLog == 7, "R4 eq flags", eqLog, 7);

    // R10: retry with nothing failed is ignored
    retry('hF, "R10 retry ignored busy", 1'b0);
    expectEnd("R10 no failure", 0, 5, 0);

    // R3: Gen2 is the highest common rate
    setup(1'b1, 1, 15, 0, 1'b0, 1'b0, 'hF);
    startLink("R11 busy gen2", 1'b1);
    expectEnd("R3 gen2 only", 2, 2, 0);
    check(eqLog == 0, "R3 no eq", eqLog, 0);

    // R3: Gen3 common but disabled, Gen2 enabled
    setup(1'b1, 3, 3, 14, 1'b0, 1'b0, 'hF);
    startLink("R11 busy gen2b", 1'b1);
    expectEnd("R3 gen3 disabled", 2, 2, 0);

    // R5: Gen4 and Gen5 disabled
    setup(1'b1, 15, 15, 12, 1'b0, 1'b0, 'hF);
    startLink("R11 busy mask12", 1'b1);
    expectEnd("R5 stop at gen3", 3, 3, 0);

    // R5: Gen5 not common
    setup(1'b1, 7, 15, 0, 1'b0, 1'b0, 'hF);
    startLink("R11 busy gen4", 1'b1);
    expectEnd("R5 stop at gen4", 34, 4, 0);

    // R7: Gen5 attempt fails, then R10 retry succeeds
    setup(1'b1, 15, 15, 0, 1'b0, 1'b0, 'b011);
    startLink("R11 busy fail5", 1'b1);
    expectEnd("R7 fail at gen5", 345, 4, 0);
    retry('h1, "R10 retry busy", 1'b1);
    expectEnd("R10 retry gen5", 5, 5, 0);

    // R7: Gen4 attempt fails
    setup(1'b1, 15, 15, 0, 1'b0, 1'b0, 'b01);
    startLink("R11 busy fail4", 1'b1);
    expectEnd("R7 fail at gen4", 34, 3, 0);

    // R7: Gen3 attempt fails, retry fails again
    setup(1'b1, 15, 15, 0, 1'b0, 1'b0, 'b0);
    startLink("R11 busy fail3", 1'b1);
    expectEnd("R7 fail at gen3", 3, 1, 0);
    retry('h0, "R10 retry busy again", 1'b1);
    expectEnd("R10 retry fails", 3, 1, 0);

    // R9: illegal strict mask
    setup(1'b1, 15, 15, 4, 1'b0, 1'b0, 'hF);
    startLink("R11 busy err", 1'b1);
    expectEnd("R9 strict illegal", 0, 1, 1);

    // R9: 1000 illegal once no-eq is advertised
    setup(1'b1, 15, 15, 8, 1'b1, 1'b0, 'hF);
    startLink("R11 busy err2", 1'b1);
    expectEnd("R9 relaxed illegal", 0, 1, 1);

    // R9: 1110 legal with bypass advertised
    setup(1'b1, 15, 15, 14, 1'b0, 1'b1, 'hF);
    startLink("R11 busy legal", 1'b1);
    expectEnd("R9 relaxed legal", 2, 2, 0);

    check(stabErr == 0, "R8 target stable while waiting", stabErr, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule